// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Alternating Byte Launch

This block turns a recovered serial bit stream into 20-bit parallel words, each made of two 10-bit bytes. Every bit arrives with a one-cycle strobe. The strobe can come from the recovered bit timing or, for test, from an external clock enable. A rate input either accepts every strobe or accepts only one strobe in each pair. The block builds two byte clocks from the count of accepted bits. The two clocks are complements of each other, and each has a period of one word.

A mode input chooses how the bytes reach the output bus. In alternating mode the lower byte is launched when byte clock 0 falls. The upper byte of the same word is launched half a word later, when byte clock 1 falls. Each byte therefore stays stable for a whole byte-clock period, and downstream logic can capture the two bytes on separate edges. In combined mode both bytes are launched together when byte clock 0 falls. Clock recovery, word alignment and all analog functions sit outside this block.

Top module: `pp_deser`

## Requirements
- R1: The output `rx_o` carries byte 0 in bits 9..0 and byte 1 in bits 19..10.
- R2: The first accepted bit of a word lands in `rx_o[0]`, and later bits fill ascending positions up to `rx_o[19]`.
- R3: `bclk1_o` is always the complement of `bclk0_o`. Each byte clock has a period of 20 accepted bits. `bclk0_o` falls in the cycle after the 20th bit of a word is accepted and rises after the 10th bit of the next word. Without accepted bits, neither clock changes.
- R4: With `pp_mode_i` high, `rx_o[9:0]` updates only when `bclk0_o` falls. `rx_o[19:10]` updates only when `bclk1_o` falls, and it then takes the upper half of the word whose lower half was launched on the preceding `bclk0_o` fall.
- R5: With `pp_mode_i` low, the whole of `rx_o` takes the completed word when `bclk0_o` falls.
- R6: With `rate_full_i` high, every strobe accepts a bit. With it low, strobes alternate between discarded and accepted, starting with a discarded strobe after reset. A discarded strobe has no effect on any output.
- R7: With `test_sel_n_i` low, `ext_en_i` is the strobe and `bit_en_i` is ignored. With it high, `bit_en_i` is the strobe and `ext_en_i` is ignored.
- R8: A synchronous reset (`rst_i` high) drives `rx_o` to zero, `bclk0_o` high and `bclk1_o` low, and clears the partly assembled word.
- R9: After reset, `rx_o` stays zero until the first `bclk0_o` fall, which follows the 20th accepted bit.
- R10: Between its launch events, each output byte holds its value, whatever the serial input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ser_i | input | 1 | Serial data bit, sampled on an accepted strobe |
| bit_en_i | input | 1 | Strobe derived from the recovered bit timing |
| ext_en_i | input | 1 | External test strobe |
| test_sel_n_i | input | 1 | Low selects the external test strobe |
| rate_full_i | input | 1 | High: full rate; low: half rate |
| pp_mode_i | input | 1 | High: alternating byte launch; low: combined launch |
| rx_o | output | 20 | Parallel output, byte 1 above byte 0 |
| bclk0_o | output | 1 | Byte clock 0 |
| bclk1_o | output | 1 | Byte clock 1, complement of byte clock 0 |

## Verification
The bench checks the bit order with asymmetric words, so a design that shifted the wrong way would present a bit-reversed word. In alternating mode it checks that byte 1 follows byte 0 by ten bits and carries the upper half of the same word. A design that loaded the upper byte together with the lower byte, or one word late, would show a different value in `rx_o[19:10]`. At half rate the discarded strobes carry inverted data, so a design that accepted the wrong strobe of a pair would assemble a corrupted word. The bench also toggles the ignored strobe during bypass, resets the block in the middle of a word, and checks that no output moves before the first full word.

// File: rtl/pp_deser_pkg.sv
package pp_deser_pkg;
  function automatic int word_width(input int byte_w);
    return 2 * byte_w;
  endfunction

  function automatic int count_width(input int byte_w);
    return $clog2(2 * byte_w);
  endfunction

  function automatic logic at_index(input int cnt, input int idx);
    return cnt == idx;
  endfunction
endpackage

// File: rtl/pp_deser_strobe.sv
module pp_deser_strobe (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bit_en_i,
  input  logic ext_en_i,
  input  logic test_sel_n_i,
  input  logic rate_full_i,
  output logic accept_o
);
  logic strobe;
  logic phase_q;

  assign strobe   = test_sel_n_i ? bit_en_i : ext_en_i;
  assign accept_o = strobe && (rate_full_i || phase_q);

  always_ff @(posedge clk_i) begin
    if (rst_i || rate_full_i) begin
      phase_q <= 1'b0;
    end else if (strobe) begin
      phase_q <= ~phase_q;
    end
  end
endmodule

// File: rtl/pp_deser_shift.sv
module pp_deser_shift
  import pp_deser_pkg::*;
#(
  parameter int BYTE_W = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic                          accept_i,
  input  logic                          ser_i,
  output logic [word_width(BYTE_W)-1:0] word_o,
  output logic                          word_done_o,
  output logic                          half_done_o
);
  localparam int WORD_W = word_width(BYTE_W);
  localparam int CNT_W  = count_width(BYTE_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign word_o      = {ser_i, sh_q[WORD_W-1:1]};
  assign word_done_o = accept_i && at_index(int'(cnt_q), WORD_W - 1);
  assign half_done_o = accept_i && at_index(int'(cnt_q), BYTE_W - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (accept_i) begin
      sh_q <= {ser_i, sh_q[WORD_W-1:1]};
      if (word_done_o) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_deser_launch.sv
module pp_deser_launch
  import pp_deser_pkg::*;
#(
  parameter int BYTE_W = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic                          pp_mode_i,
  input  logic                          word_done_i,
  input  logic                          half_done_i,
  input  logic [word_width(BYTE_W)-1:0] word_i,
  output logic [word_width(BYTE_W)-1:0] rx_o,
  output logic                          bclk0_o,
  output logic                          bclk1_o,
  output logic                          bclk1_fall_o
);
  localparam int WORD_W = word_width(BYTE_W);

  logic [BYTE_W-1:0] hold_q;

  assign bclk1_fall_o = half_done_i && bclk1_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rx_o    <= '0;
      hold_q  <= '0;
      bclk0_o <= 1'b1;
      bclk1_o <= 1'b0;
    end else if (word_done_i) begin
      bclk0_o           <= 1'b0;
      bclk1_o           <= 1'b1;
      hold_q            <= word_i[WORD_W-1:BYTE_W];
      rx_o[BYTE_W-1:0]  <= word_i[BYTE_W-1:0];
      if (!pp_mode_i) begin
        rx_o[WORD_W-1:BYTE_W] <= word_i[WORD_W-1:BYTE_W];
      end
    end else if (half_done_i) begin
      bclk0_o <= 1'b1;
      bclk1_o <= 1'b0;
      if (pp_mode_i && bclk1_o) begin
        rx_o[WORD_W-1:BYTE_W] <= hold_q;
      end
    end
  end
endmodule

// File: rtl/pp_deser.sv
module pp_deser
  import pp_deser_pkg::*;
#(
  parameter int BYTE_W = 10
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic                          ser_i,
  input  logic                          bit_en_i,
  input  logic                          ext_en_i,
  input  logic                          test_sel_n_i,
  input  logic                          rate_full_i,
  input  logic                          pp_mode_i,
  output logic [word_width(BYTE_W)-1:0] rx_o,
  output logic                          bclk0_o,
  output logic                          bclk1_o
);
  localparam int WORD_W = word_width(BYTE_W);

  logic              accept;
  logic              word_done;
  logic              half_done;
  logic              bclk1_fall;
  logic [WORD_W-1:0] word;

  pp_deser_strobe strobe_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .bit_en_i     (bit_en_i),
    .ext_en_i     (ext_en_i),
    .test_sel_n_i (test_sel_n_i),
    .rate_full_i  (rate_full_i),
    .accept_o     (accept)
  );

  pp_deser_shift #(.BYTE_W(BYTE_W)) shift_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .accept_i    (accept),
    .ser_i       (ser_i),
    .word_o      (word),
    .word_done_o (word_done),
    .half_done_o (half_done)
  );

  pp_deser_launch #(.BYTE_W(BYTE_W)) launch_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .pp_mode_i    (pp_mode_i),
    .word_done_i  (word_done),
    .half_done_i  (half_done),
    .word_i       (word),
    .rx_o         (rx_o),
    .bclk0_o      (bclk0_o),
    .bclk1_o      (bclk1_o),
    .bclk1_fall_o (bclk1_fall)
  );
endmodule

// File: rtl/pp_deser_chk.sv
module pp_deser_chk #(
  parameter int BYTE_W = 10
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic                  pp_mode_i,
  input logic                  accept_i,
  input logic                  word_done_i,
  input logic                  bclk1_fall_i,
  input logic [2*BYTE_W-1:0]   rx_i,
  input logic                  bclk0_i,
  input logic                  bclk1_i
);
  localparam int WORD_W = 2 * BYTE_W;

  logic rst_q = 1'b0;

  always_ff @(posedge clk_i) rst_q <= rst_i;

  always @(posedge clk_i) begin
    if (rst_q) begin
      AST_RESET_STATE: assert (rx_i == '0 && bclk0_i && !bclk1_i)
        else $error("reset state wrong"); // R8
    end
  end

  AST_CLK_COMPL: assert property (@(posedge clk_i) disable iff (rst_i)
    bclk1_i == !bclk0_i) else $error("byte clocks not complementary"); // R3

  AST_WORD_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    word_done_i |=> (!bclk0_i && bclk1_i)) else $error("no fall after word"); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !accept_i |=> $stable(bclk0_i)) else $error("clock moved without a bit"); // R6

  AST_LO_LAUNCH: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(rx_i[BYTE_W-1:0]) |-> $past(word_done_i))
    else $error("byte 0 changed off its edge"); // R10

  AST_HI_LAUNCH: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(rx_i[WORD_W-1:BYTE_W]) |->
      ($past(pp_mode_i) ? $past(bclk1_fall_i) : $past(word_done_i)))
    else $error("byte 1 changed off its edge"); // R4
endmodule

bind pp_deser pp_deser_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .pp_mode_i    (pp_mode_i),
  .accept_i     (accept),
  .word_done_i  (word_done),
  .bclk1_fall_i (bclk1_fall),
  .rx_i         (rx_o),
  .bclk0_i      (bclk0_o),
  .bclk1_i      (bclk1_o)
);

// File: tb/pp_deser_tb_top.sv
module pp_deser_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser = 1'b0;
  logic        bit_en = 1'b0;
  logic        ext_en = 1'b0;
  logic        tsn = 1'b1;
  logic        rate_full = 1'b1;
  logic        pp = 1'b0;
  logic [19:0] rx;
  logic        b0;
  logic        b1;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pp_deser dut_i (
    .clk_i        (clk),
    .rst_i        (rst),
    .ser_i        (ser),
    .bit_en_i     (bit_en),
    .ext_en_i     (ext_en),
    .test_sel_n_i (tsn),
    .rate_full_i  (rate_full),
    .pp_mode_i    (pp),
    .rx_o         (rx),
    .bclk0_o      (b0),
    .bclk1_o      (b1)
  );

  // Behavioural reference: a queue of accepted bits and event-driven outputs.
  logic        q[$];
  logic [19:0] m_rx;
  logic        m_b0;
  logic        m_b1;
  logic [9:0]  m_pend;
  bit          m_phase;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_rx = '0; m_b0 = 1'b1; m_b1 = 1'b0; m_pend = '0; m_phase = 1'b0;
    end else begin
      bit stb;
      bit take;
      stb  = tsn ? bit_en : ext_en;
      take = stb && (rate_full || m_phase);
      if (rate_full) m_phase = 1'b0;
      else if (stb) m_phase = !m_phase;
      if (take) begin
        q.push_back(ser);
        if (q.size() == 20) begin
          logic [19:0] w;
          for (int i = 0; i < 20; i++) w[i] = q[i];
          q.delete();
          m_b0 = 1'b0; m_b1 = 1'b1;
          m_pend = w[19:10];
          m_rx[9:0] = w[9:0];
          if (!pp) m_rx[19:10] = w[19:10];
        end else if (q.size() == 10) begin
          if (pp && m_b1) m_rx[19:10] = m_pend;
          m_b0 = 1'b1; m_b1 = 1'b0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(b0 === m_b0 && b1 === m_b1, "R3 R6 R7 byte clocks", {18'b0, b1, b0}, {18'b0, m_b1, m_b0});
      check(rx === m_rx, pp ? "R4 R10 rx" : "R5 R10 rx", rx, m_rx);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 1'b0; ext_en = 1'b0; ser = $urandom_range(0, 1);
    end
  endtask

  // One bit; at half rate a discarded strobe with inverted data goes first.
  task automatic put_bit(input logic b);
    if (!rate_full) begin
      @(negedge clk);
      ser = !b;
      if (tsn) begin bit_en = 1'b1; ext_en = 1'b0; end
      else begin ext_en = 1'b1; bit_en = 1'b1; end
    end
    @(negedge clk);
    ser = b;
    if (tsn) begin bit_en = 1'b1; ext_en = !ext_en; end
    else begin ext_en = 1'b1; bit_en = !bit_en; end
  endtask

  task automatic send_bits(input logic [19:0] w, input int from, input int to);
    for (int i = from; i <= to; i++) put_bit(w[i]);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_en = 1'b0; ext_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(rx === 20'h0 && b0 === 1'b1 && b1 === 1'b0, "R8 reset state", {b1, b0, rx[17:0]}, 20'h80000 >> 1);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 20000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    do_reset();
    // R9: nineteen bits give no output; the twentieth launches the word. R1 R2
    pp = 1'b0;
    send_bits(20'hABCDE, 0, 18);
    idle(1);
    check(rx === 20'h0 && b0 === 1'b1, "R9 no early output", rx, 20'h0);
    send_bits(20'hABCDE, 19, 19);
    idle(1);
    check(rx === 20'hABCDE, "R1 R2 R5 combined word", rx, 20'hABCDE);
    check(b0 === 1'b0 && b1 === 1'b1, "R3 fall after word", {18'b0, b1, b0}, 20'h2);
    // R4: alternating launch
    pp = 1'b1;
    send_bits(20'h12345, 0, 19);
    idle(2);
    check(rx === {10'h2AF, 10'h345}, "R4 byte0 only", rx, {10'h2AF, 10'h345});
    send_bits(20'h0F00F, 0, 8);
    idle(1);
    check(rx === {10'h2AF, 10'h345}, "R10 hold before half", rx, {10'h2AF, 10'h345});
    send_bits(20'h0F00F, 9, 9);
    idle(1);
    check(rx === {10'h048, 10'h345}, "R4 byte1 upper half", rx, {10'h048, 10'h345});
    send_bits(20'h0F00F, 10, 19);
    idle(3);
    // R6: half rate, discarded strobes carry inverted data
    do_reset();
    rate_full = 1'b0; pp = 1'b0;
    send_bits(20'h0F0F0, 0, 19);
    idle(1);
    check(rx === 20'h0F0F0, "R6 half rate word", rx, 20'h0F0F0);
    // R7: bypass strobe, recovered strobe toggled as noise
    do_reset();
    rate_full = 1'b1; tsn = 1'b0; pp = 1'b1;
    send_bits(20'h5A5A5, 0, 19);
    idle(1);
    check(rx[9:0] === 10'h1A5, "R7 bypass strobe", rx, {10'h0, 10'h1A5});
    send_bits(20'hFFFFF, 0, 9);
    idle(1);
    check(rx === {10'h169, 10'h1A5}, "R7 R4 bypass upper", rx, {10'h169, 10'h1A5});
    // R8: reset in the middle of a word
    do_reset();
    tsn = 1'b1; pp = 1'b0;
    send_bits(20'h33333, 0, 19);
    idle(1);
    check(rx === 20'h33333, "R8 word after mid reset", rx, 20'h33333);
    // mixed gaps and mode changes, checked against the model every cycle
    for (int k = 0; k < 30; k++) begin
      pp = k[0];
      rate_full = (k % 3) != 0;
      for (int i = 0; i < 20; i++) begin
        put_bit($urandom_range(0, 1));
        if ($urandom_range(0, 3) == 0) idle(1);
      end
    end
    idle(5);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule